// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a byte-wide nonvolatile memory reached over a four-wire serial bus in mode 0. It samples chip select, serial clock, serial data in, a pause input and a write-protect input on the system clock. It shifts in an 8-bit opcode, collects a 16-bit address when one is needed, and then either streams array bytes out or gathers bytes into a 32-byte page buffer. The array holds 2**MEM_AW bytes; the full-size part uses MEM_AW = 13.

Status and write-enable handling lives in a separate protection unit. The front end hands that unit its opcodes and asks it before any page commit. An accepted commit copies the page buffer into the array during a simulated busy interval. A pause input freezes the serial sequence mid-transfer and lets it continue from the same bit. The serial clock must stay in each phase for at least three system clocks.

Top module: `spi_mem_top`

## Requirements
- R1: After reset so_oe is low and a status read returns 0x00.
- R2: Opcodes are 8 bits, sent MSB first and sampled on rising SCK while cs_n is low. Opcode 0x06 sets the write-enable flag and 0x04 clears it. Unknown opcodes are ignored until cs_n rises. The status byte has the lock-enable bit in bit 7, a region code in bits 3:2, the write-enable flag in bit 1, the busy flag in bit 0, and zeros in bits 6:4.
- R3: Opcode 0x05 shifts the status byte out MSB first on falling SCK edges, repeating it for as long as clocks continue. While busy it reads 0xFF.
- R4: Opcode 0x01 followed by one byte loads bits 7, 3 and 2 of that byte. The load is accepted only when write-enable is 1 and not (lock-enable is 1 and wp_n is low). A rejected load changes nothing. An accepted one starts a busy interval.
- R5: Opcode 0x03 takes a 16-bit MSB-first address whose upper 16-MEM_AW bits are ignored. The first data bit is driven on the falling SCK after the last address bit. The address increments per byte and wraps from the last byte to 0. SCK may stop for any length of time without losing position.
- R6: Opcode 0x02 takes a 16-bit address and then data bytes. Byte k goes to page base + ((start offset + k) mod 32), so a later byte replaces an earlier one in the same slot.
- R7: A page is committed only when cs_n rises after a whole number (at least one) of data bytes while write-enable is 1. Otherwise nothing is written, no busy interval starts and write-enable is unchanged.
- R8: Region code 00 locks nothing, 01 the top quarter of the array, 10 the top half, and 11 all of it. A page write into a locked region is not committed.
- R9: A commit or an accepted status load holds the busy flag at 1 for BUSY_CYCLES clocks. When the busy flag clears, write-enable clears at the same edge.
- R10: While busy, only opcode 0x05 is acted on. All other opcodes are ignored, including reads, and so_oe stays low for them.
- R11: A pause starts only when hold_n falls while SCK is low, and ends only when hold_n rises while SCK is low. SCK edges during a pause are ignored. The transfer then continues at the same bit. A change of hold_n while SCK is high has no effect.
- R12: so_oe is high only while cs_n is low, no pause is active, and the block is in a data or status output phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect for the status load, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |

## Verification
Every serial pin passes through one input register and an edge detector. A new output bit therefore appears about two system clocks after the falling SCK that launches it. The bench samples so on a falling system-clock edge at the end of each SCK low phase, just before the rising SCK, so each bit is read well after it is due. A commit starts two clocks after cs_n rises, and a status read begun eight clocks later must see 0xFF. The bench then polls the status until the busy flag clears and only reads the array after that. Pause checks on so_oe are made several clocks after hold_n moves, past the two-register latency.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes and front-end state encoding for the serial memory block.
package spi_mem_pkg;
    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_WRITE   = 8'h02;

    typedef enum logic [2:0] {
        ST_OP, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRRD, ST_SRWR, ST_IGNORE
    } fe_state_t;
endpackage

// File: rtl/spi_mem_prot.sv
// Protection unit: write-enable flag, lock-enable bit, region code and the
// busy interval timer. Assumes the front end raises at most one request per
// cycle and sends no set/clear requests while busy.
module spi_mem_prot #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set_i,
    input  logic       wel_clr_i,
    input  logic       sr_wr_i,
    input  logic [2:0] sr_bits_i,   // {lock-enable, region[1:0]}
    input  logic       wp_n_i,
    input  logic       page_wr_i,
    input  logic [1:0] region_i,    // top two address bits of the target
    output logic [7:0] status_o,
    output logic       wel_o,
    output logic       wip_o,
    output logic       locked_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic             wel_q, wpen_q;
    logic [1:0]       bp_q;
    logic [CNT_W-1:0] busy_cnt;
    logic             sr_accept, start_busy;

    assign wip_o      = (busy_cnt != '0);
    assign wel_o      = wel_q;
    assign sr_accept  = sr_wr_i && wel_q && !(wpen_q && !wp_n_i) && !wip_o;
    assign start_busy = sr_accept || page_wr_i;
    assign status_o   = wip_o ? 8'hFF : {wpen_q, 3'b000, bp_q, wel_q, 1'b0};

    // Region lookup: decide whether the addressed quarter is locked.
    always_comb begin
        case (bp_q)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = (region_i == 2'b11);
            2'b10:   locked_o = region_i[1];
            default: locked_o = 1'b1;
        endcase
    end

    // Register updates: busy timer, write-enable flag and protection bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            wel_q    <= 1'b0;
            wpen_q   <= 1'b0;
            bp_q     <= 2'b00;
        end else begin
            if (start_busy)
                busy_cnt <= CNT_W'(BUSY_CYCLES);
            else if (wip_o)
                busy_cnt <= busy_cnt - CNT_W'(1);
            if (busy_cnt == CNT_W'(1))
                wel_q <= 1'b0;
            else if (wel_clr_i)
                wel_q <= 1'b0;
            else if (wel_set_i)
                wel_q <= 1'b1;
            if (sr_accept) begin
                wpen_q <= sr_bits_i[2];
                bp_q   <= sr_bits_i[1:0];
            end
        end
    end

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_o) |-> $past(page_wr_i || sr_wr_i));
    assert_wel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_o) |-> !wel_o);
    assert_bits_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp_q) |-> $past(sr_wr_i && wel_q));
    assert_commit_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr_i |-> wel_q && !wip_o);
endmodule

// File: rtl/spi_mem_store.sv
// Byte array with a page buffer. Buffered bytes are copied into the array
// one per clock after a commit. Assumes the busy interval is at least one
// page long, so the buffer is not cleared during a copy.
module spi_mem_store #(
    parameter int MEM_AW     = 11,
    parameter int PAGE_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [MEM_AW-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o,
    input  logic                     buf_clr_i,
    input  logic                     buf_we_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] buf_off_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     commit_i,
    input  logic [MEM_AW-$clog2(PAGE_BYTES)-1:0] page_i
);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0]           mem [DEPTH];
    logic [7:0]           pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic                 active;
    logic [PW-1:0]        idx;
    logic [MEM_AW-PW-1:0] page_q;

    assign rd_data_o = mem[rd_addr_i];

    // Buffer valid mask: cleared at the start of each write frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pvalid <= '0;
        else if (buf_clr_i)
            pvalid <= '0;
        else if (buf_we_i)
            pvalid[buf_off_i] <= 1'b1;
    end

    // Buffer data: latest byte for each slot.
    always_ff @(posedge clk) begin
        if (buf_we_i)
            pbuf[buf_off_i] <= buf_data_i;
    end

    // Copy engine: walks the slots once after a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            page_q <= '0;
        end else if (commit_i) begin
            active <= 1'b1;
            idx    <= '0;
            page_q <= page_i;
        end else if (active) begin
            idx <= idx + PW'(1);
            if (idx == PW'(PAGE_BYTES - 1))
                active <= 1'b0;
        end
    end

    // Array write port: stores only the slots that received data.
    always_ff @(posedge clk) begin
        if (active && pvalid[idx])
            mem[{page_q, idx}] <= pbuf[idx];
    end

    assert_commit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> !active);
    assert_buffer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !buf_clr_i);
endmodule

// File: rtl/spi_mem_top.sv
// Serial front end: samples the bus pins, decodes opcodes, collects the
// address, streams bytes out or into the page buffer, and handles pause.
// Assumes each SCK phase lasts at least three clk cycles.
module spi_mem_top
    import spi_mem_pkg::*;
#(
    parameter int MEM_AW      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic cs_q, cs_p, sck_q, sck_p, si_q, hold_q, hold_p, wp_q;
    logic paused;
    fe_state_t state;
    logic [2:0]        bcnt;
    logic [6:0]        sr;
    logic [MEM_AW-9:0] addr_hi;
    logic [MEM_AW-1:0] addr;
    logic addr_phase, is_write, load_pend, load_stat, got_byte;
    logic [7:0] tx_byte, din, status, rd_data;
    logic so_q, rise, fall, byte_done, op_ok, cs_rise;
    logic wel, wip, locked, commit;

    // Pin sampling: one register stage plus history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1; cs_p <= 1'b1; sck_q <= 1'b0; sck_p <= 1'b0;
            si_q <= 1'b0; hold_q <= 1'b1; hold_p <= 1'b1; wp_q <= 1'b1;
        end else begin
            cs_q <= cs_n; cs_p <= cs_q; sck_q <= sck; sck_p <= sck_q;
            si_q <= si; hold_q <= hold_n; hold_p <= hold_q; wp_q <= wp_n;
        end
    end

    assign rise      = sck_q && !sck_p && !cs_q && !paused;
    assign fall      = !sck_q && sck_p && !cs_q && !paused;
    assign cs_rise   = cs_q && !cs_p;
    assign din       = {sr, si_q};
    assign byte_done = rise && (bcnt == 3'd7);
    assign op_ok     = byte_done && (state == ST_OP) && !wip;
    assign commit    = cs_rise && (state == ST_WDATA) && (bcnt == 3'd0)
                       && got_byte && wel && !locked;

    // Pause control: enter and leave only while SCK is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_q)
            paused <= 1'b0;
        else if (!paused && hold_p && !hold_q && !sck_q)
            paused <= 1'b1;
        else if (paused && !hold_p && hold_q && !sck_q)
            paused <= 1'b0;
    end

    // Frame sequencer: opcode, address and data handling per SCK edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OP; bcnt <= '0; sr <= '0; addr <= '0; addr_hi <= '0;
            addr_phase <= 1'b0; is_write <= 1'b0; tx_byte <= '0; so_q <= 1'b0;
            load_pend <= 1'b0; load_stat <= 1'b0; got_byte <= 1'b0;
        end else if (cs_q) begin
            state <= ST_OP; bcnt <= '0; addr_phase <= 1'b0;
            load_pend <= 1'b0; got_byte <= 1'b0;
        end else if (load_pend) begin
            tx_byte   <= load_stat ? status : rd_data;
            load_pend <= 1'b0;
            if (!load_stat)
                addr <= addr + MEM_AW'(1);
        end else if (rise) begin
            sr   <= din[6:0];
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
                case (state)
                    ST_OP: begin
                        if (wip && din != OP_RD_STAT)
                            state <= ST_IGNORE;
                        else if (din == OP_RD_STAT) begin
                            state <= ST_SRRD; load_pend <= 1'b1; load_stat <= 1'b1;
                        end else if (din == OP_WR_STAT)
                            state <= ST_SRWR;
                        else if (din == OP_READ || din == OP_WRITE) begin
                            state <= ST_ADDR; is_write <= (din == OP_WRITE);
                            load_stat <= 1'b0;
                        end else
                            state <= ST_IGNORE;
                    end
                    ST_ADDR: begin
                        if (!addr_phase) begin
                            addr_phase <= 1'b1;
                            addr_hi    <= din[MEM_AW-9:0];
                        end else begin
                            addr <= {addr_hi, din};
                            if (is_write)
                                state <= ST_WDATA;
                            else begin
                                state <= ST_RDATA; load_pend <= 1'b1;
                            end
                        end
                    end
                    ST_RDATA, ST_SRRD: load_pend <= 1'b1;
                    ST_WDATA: begin
                        addr     <= {addr[MEM_AW-1:PW], addr[PW-1:0] + PW'(1)};
                        got_byte <= 1'b1;
                    end
                    ST_SRWR: state <= ST_IGNORE;
                    default: ;
                endcase
            end
        end else if (fall && (state == ST_RDATA || state == ST_SRRD)) begin
            so_q <= tx_byte[3'd7 - bcnt];
        end
    end

    assign so    = so_q;
    assign so_oe = !cs_q && !paused && (state == ST_RDATA || state == ST_SRRD);

    spi_mem_prot #(.BUSY_CYCLES(BUSY_CYCLES)) prot_i (
        .clk(clk), .rst_n(rst_n),
        .wel_set_i(op_ok && din == OP_SET_WEL),
        .wel_clr_i(op_ok && din == OP_CLR_WEL),
        .sr_wr_i(byte_done && state == ST_SRWR),
        .sr_bits_i({din[7], din[3:2]}),
        .wp_n_i(wp_q), .page_wr_i(commit),
        .region_i(addr[MEM_AW-1 -: 2]),
        .status_o(status), .wel_o(wel), .wip_o(wip), .locked_o(locked)
    );

    spi_mem_store #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_i(addr), .rd_data_o(rd_data),
        .buf_clr_i(op_ok && din == OP_WRITE),
        .buf_we_i(byte_done && state == ST_WDATA),
        .buf_off_i(addr[PW-1:0]), .buf_data_i(din),
        .commit_i(commit), .page_i(addr[MEM_AW-1:PW])
    );

    assert_pause_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        paused && $past(paused) |-> $stable(bcnt) && $stable(state));
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && state == ST_OP && wip && din != OP_RD_STAT |=> state == ST_IGNORE);
endmodule

// File: tb/spi_mem_top_tb_top.sv
// Bench: directed corner cases plus seeded random page writes, checked
// against a byte model and a status model kept in the bench.
module spi_mem_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int AW         = 11;
    localparam int DEPTH      = 1 << AW;
    localparam int BUSY       = 300;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic hold_n = 1'b1, wp_n = 1'b1;
    wire  so, so_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_top #(.MEM_AW(AW), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

    int checks = 0, failures = 0;
    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    logic [7:0] wbuf [64];
    bit         wel_m = 0, wpen_m = 0;
    logic [1:0] bp_m = 2'b00;

    function automatic bit prot_m(int a);
        case (bp_m)
            2'b00:   return 1'b0;
            2'b01:   return ((a >> 9) & 3) == 3;
            2'b10:   return ((a >> 10) & 1) == 1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] stat_m();
        return {wpen_m, 3'b000, bp_m, wel_m, 1'b0};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        si = b; tick(HALF); r = so; sck = 1'b1; tick(HALF); sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            xbit(t[i], b); r[i] = b;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0; tick(HALF);
    endtask

    task automatic desel();
        tick(HALF); cs_n = 1'b1; tick(2*HALF);
    endtask

    task automatic cmd(logic [7:0] op);
        logic [7:0] d;
        sel(); xbyte(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xbyte(8'h05, d); xbyte(8'h00, s); desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int polls = 0;
        do begin rdsr(s); polls++; end while (s[0] && polls < 100);
        check("R9 busy ends", {31'd0, s[0]}, 32'd0);
    endtask

    task automatic wrsr(logic [7:0] v);
        logic [7:0] d, s;
        bit ok;
        ok = wel_m && !(wpen_m && !wp_n);
        sel(); xbyte(8'h01, d); xbyte(v, d); desel();
        if (ok) begin
            wpen_m = v[7]; bp_m = v[3:2];
            rdsr(s); check("R3 status during busy", s, 8'hFF);
            wait_idle(); wel_m = 0;
        end
        rdsr(s); check("R4 status after load", s, stat_m());
    endtask

    task automatic do_write(int a, int n, bit en, string tag);
        logic [7:0] d, s;
        bit ok;
        if (en) begin cmd(8'h06); wel_m = 1; end
        sel(); xbyte(8'h02, d); xbyte(8'(a >> 8), d); xbyte(8'(a), d);
        for (int k = 0; k < n; k++) xbyte(wbuf[k], d);
        desel();
        ok = wel_m && !prot_m(a) && n > 0;
        if (ok) begin
            for (int k = 0; k < n; k++) begin
                int t;
                t = (a & (DEPTH - 32)) | ((a + k) & 31);
                model[t] = wbuf[k]; known[t] = 1;
            end
            rdsr(s); check({tag, " busy"}, s, 8'hFF);
            wait_idle(); wel_m = 0;
        end else begin
            rdsr(s); check({tag, " no commit"}, s, stat_m());
        end
    endtask

    task automatic do_read(int a, int n, string tag);
        logic [7:0] d;
        sel(); xbyte(8'h03, d); xbyte(8'(a >> 8), d); xbyte(8'(a), d);
        for (int k = 0; k < n; k++) begin
            int t;
            xbyte(8'h00, d);
            t = (a + k) & (DEPTH - 1);
            if (known[t]) check(tag, d, model[t]);
        end
        desel();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] s, d;
        logic b;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        tick(5); rst_n = 1'b1; tick(3);

        // R1 reset state
        check("R1 so_oe after reset", {31'd0, so_oe}, 32'd0);
        rdsr(s); check("R1 status after reset", s, 8'h00);

        // R2 write-enable set and clear, unknown opcode
        cmd(8'h06); wel_m = 1; rdsr(s); check("R2 set wel", s, 8'h02);
        cmd(8'hA5); rdsr(s); check("R2 unknown opcode", s, 8'h02);
        cmd(8'h04); wel_m = 0; rdsr(s); check("R2 clear wel", s, 8'h00);

        // R7 write without enable, then baseline data
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h10 + 8'(k);
        do_write(16'h0100, 4, 1, "R7 baseline");
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hE0 + 8'(k);
        do_write(16'h0100, 4, 0, "R7 no wel");
        do_read(16'h0100, 4, "R7 data kept without wel");

        // R7 partial byte: no commit, wel kept
        cmd(8'h06); wel_m = 1;
        sel(); xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h00, d); xbyte(8'h77, d);
        for (int i = 0; i < 3; i++) xbit(1'b1, b);
        desel();
        rdsr(s); check("R7 partial byte no commit", s, 8'h02);
        cmd(8'h04); wel_m = 0;
        do_read(16'h0100, 2, "R7 partial byte data kept");

        // R10 busy ignores writes-enable and reads
        wbuf[0] = 8'h5A;
        cmd(8'h06); wel_m = 1;
        sel(); xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h10, d); xbyte(wbuf[0], d); desel();
        model[16'h0110] = wbuf[0]; known[16'h0110] = 1;
        cmd(8'h06);
        sel(); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'h10, d); xbyte(8'h00, d);
        check("R10 so_oe low for read while busy", {31'd0, so_oe}, 32'd0);
        desel();
        wait_idle(); wel_m = 0;
        rdsr(s); check("R10 enable ignored while busy", s, 8'h00);

        // R6 page wrap and overwrite
        for (int k = 0; k < 5; k++) wbuf[k] = 8'hA0 + 8'(k);
        do_write(16'h021E, 5, 1, "R6 wrap");
        do_read(16'h0200, 3, "R6 wrapped bytes");
        do_read(16'h021E, 2, "R6 first bytes");
        for (int k = 0; k < 34; k++) wbuf[k] = 8'h40 + 8'(k);
        do_write(16'h0240, 34, 1, "R6 overflow");
        do_read(16'h0240, 3, "R6 overwritten slots");

        // R5 read wrap at array end and ignored upper address bits
        for (int k = 0; k < 2; k++) wbuf[k] = 8'hC0 + 8'(k);
        do_write(DEPTH - 2, 2, 1, "R5 top");
        for (int k = 0; k < 2; k++) wbuf[k] = 8'hD0 + 8'(k);
        do_write(0, 2, 1, "R5 bottom");
        do_read(DEPTH - 2, 4, "R5 read wrap");
        do_read(16'hFFFE, 4, "R5 upper bits ignored");

        // R4 status loads, R8 regions
        wrsr(8'h84);
        cmd(8'h06); wel_m = 1; wrsr(8'h84);
        for (int k = 0; k < 2; k++) wbuf[k] = 8'h99;
        do_write(16'h07E0, 2, 1, "R8 top quarter locked");
        do_read(16'h07FE, 2, "R8 locked data kept");
        do_write(16'h05E0, 2, 1, "R8 below top quarter");
        do_read(16'h05E0, 2, "R8 written");
        wp_n = 1'b0; tick(2);
        cmd(8'h06); wel_m = 1; wrsr(8'h00);
        wp_n = 1'b1; tick(2);
        wrsr(8'h08);
        for (int k = 0; k < 2; k++) wbuf[k] = 8'h33;
        do_write(16'h05E0, 2, 1, "R8 half locked");
        do_read(16'h05E0, 2, "R8 half data kept");
        cmd(8'h06); wel_m = 1; wrsr(8'h0C);
        do_write(16'h0010, 2, 1, "R8 all locked");
        cmd(8'h06); wel_m = 1; wrsr(8'h00);

        // R11 pause in the data phase, static clock, hold while SCK high
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h6C + 8'(k * 3);
        do_write(16'h0300, 8, 1, "R11 setup");
        sel(); xbyte(8'h03, d); xbyte(8'h03, d); xbyte(8'h00, d);
        for (int i = 7; i >= 5; i--) begin xbit(1'b0, b); d[i] = b; end
        check("R12 so_oe in data phase", {31'd0, so_oe}, 32'd1);
        hold_n = 1'b0; tick(4);
        check("R11 paused output off", {31'd0, so_oe}, 32'd0);
        for (int i = 0; i < 3; i++) begin sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); end
        tick(1000);
        hold_n = 1'b1; tick(4);
        check("R12 so_oe after resume", {31'd0, so_oe}, 32'd1);
        for (int i = 4; i >= 0; i--) begin xbit(1'b0, b); d[i] = b; end
        check("R11 byte across pause", d, model[16'h0300]);
        si = 1'b0; tick(HALF); d[7] = so; sck = 1'b1; tick(2);
        hold_n = 1'b0; tick(2); sck = 1'b0; tick(3);
        check("R11 hold while SCK high ignored", {31'd0, so_oe}, 32'd1);
        hold_n = 1'b1; tick(2);
        for (int i = 6; i >= 0; i--) begin xbit(1'b0, b); d[i] = b; end
        check("R11 byte after high-phase hold", d, model[16'h0301]);
        desel();
        check("R12 so_oe after deselect", {31'd0, so_oe}, 32'd0);

        // R5 R6 seeded random page writes and reads
        for (int it = 0; it < 10; it++) begin
            int a, n;
            a = int'($urandom % 1024);
            n = 1 + int'($urandom % 12);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            do_write(a, n, 1, "R6 random write");
            do_read(a & (DEPTH - 32), 32, "R5 random read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule